// File: doc/BRIEF.md
# External Oscillator Failure Monitor

The block watches an external oscillator and decides that it has died when its frequency drops too low. The judgement uses a slow internal reference clock that is cheap but inaccurate, with an error of up to 30 percent. Both the reference and the oscillator arrive as asynchronous inputs. They are synchronized into the system clock domain and reduced to rising-edge strobes. The monitor counts oscillator edges across a window that is a fixed number of reference periods long. A window with too few edges is a failure.

The monitor is off after reset. Software can switch it on only while the configuration-protection window is open, and after that it stays on until the next reset. The response to a failure depends on whether the oscillator is the system clock at that moment:
- When the oscillator is the system clock, the block requests a forced switch to the internal 2 MHz source and also disables the oscillator.
- When the oscillator is running but not selected, the block only disables it.
- In both cases it raises a non-maskable interrupt request, sets a sticky failure flag and pulses a release of the clock-configuration lock.

Top module: `xosc_fail_monitor`

## Requirements
- R1: After reset `det_en_o`, `fail_flag_o`, `nmi_req_o`, `sw_int_o`, `xosc_off_o` and `lock_clr_o` are all 0.
- R2: A write with `wr_en_i`=1 and `wr_data_i[0]`=1 sets `det_en_o` only when `prot_open_i`=1 in the same cycle. Without the open window the write has no effect.
- R3: Once `det_en_o` is 1 it stays 1 until reset, whatever is written.
- R4: The monitor counts synchronized oscillator rising edges over windows of WIN_REFS (default 3) reference periods, each window starting on a reference rising edge. A window with fewer than MIN_EDGES (default 2) edges is a failure. An oscillator period equal to the nominal reference period never trips, even with the reference running 30 percent fast. An oscillator at a quarter of that frequency, or a stopped one, does trip.
- R5: On a failure `fail_flag_o` becomes 1, `nmi_req_o` becomes 1, and `xosc_off_o` and `lock_clr_o` each pulse high for one cycle.
- R6: `sw_int_o` pulses for one cycle on a failure only if `xosc_sel_i` was 1. A failure of an unselected oscillator produces no `sw_int_o` pulse, but it still disables the oscillator and raises the interrupt.
- R7: `lock_clr_o` pulses together with every failure response, in the cycle in which `nmi_req_o` rises.
- R8: `nmi_req_o` stays 1 until a cycle with `nmi_ack_i`=1.
- R9: `fail_flag_o` is sticky. It is cleared by a write with `wr_data_i[1]`=1, which needs no protection window.
- R10: No failure is declared while `det_en_o`=0 or `xosc_en_i`=0.
- R11: A single failure produces exactly one response. The monitor re-arms only after `xosc_en_i` has been 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Slow internal reference clock (asynchronous) |
| xosc_clk_i | input | 1 | Monitored external oscillator (asynchronous) |
| xosc_en_i | input | 1 | External oscillator is enabled |
| xosc_sel_i | input | 1 | External oscillator is the system clock source |
| prot_open_i | input | 1 | Configuration-protection window is open |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 2 | Bit 0 enable (protected), bit 1 flag clear (write one) |
| nmi_ack_i | input | 1 | Interrupt acknowledge |
| det_en_o | output | 1 | Monitor enabled |
| fail_flag_o | output | 1 | Sticky failure flag |
| nmi_req_o | output | 1 | Non-maskable interrupt request |
| sw_int_o | output | 1 | One-cycle request to force the internal 2 MHz source |
| xosc_off_o | output | 1 | One-cycle request to disable the external oscillator |
| lock_clr_o | output | 1 | One-cycle request to release the configuration lock |

## Verification
The edge counter is driven with the following oscillator patterns:
- A healthy oscillator whose period equals the nominal reference period, against a nominal reference, a reference 30 percent fast and a reference 30 percent slow. These separate a correct margin from a window or threshold set too tight.
- An oscillator at a quarter of that frequency and a fully stopped one. These show that real failures are still caught.

Stopped-oscillator runs are also repeated in three conditions:
- with the monitor disabled or the oscillator not enabled, to show that these gate detection;
- with the oscillator selected and not selected, to separate the two response paths;
- long enough to span several windows, to show that one failure yields a single response.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  typedef struct packed {
    logic sw_int;
    logic xosc_off;
    logic lock_clr;
  } xfd_resp_t;

  localparam int unsigned WrEnBit  = 0;
  localparam int unsigned WrClrBit = 1;
endpackage

// File: rtl/xfd_edge_sync.sv
module xfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/xfd_window.sv
module xfd_window #(
  parameter int unsigned WIN_REFS  = 3,
  parameter int unsigned MIN_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ref_rise_i,
  input  logic xosc_rise_i,
  output logic fail_evt_o
);
  localparam int unsigned RW = $clog2(WIN_REFS + 1);
  localparam int unsigned EW = $clog2(MIN_EDGES + 1);
  localparam logic [RW-1:0] RefLast = RW'(WIN_REFS);
  localparam logic [EW-1:0] EdgeMin = EW'(MIN_EDGES);

  logic [RW-1:0] ref_cnt_q;
  logic [EW-1:0] edge_cnt_q, edge_inc;
  logic          win_end;

  // saturating count, including an edge that coincides with window close
  always_comb begin
    edge_inc = edge_cnt_q;
    if (xosc_rise_i && edge_cnt_q != EdgeMin) edge_inc = edge_cnt_q + 1'b1;
  end

  assign win_end    = arm_i && ref_rise_i && (ref_cnt_q == RefLast);
  assign fail_evt_o = win_end && (edge_inc < EdgeMin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cnt_q  <= '0;
      edge_cnt_q <= '0;
    end else if (!arm_i) begin
      ref_cnt_q  <= '0;
      edge_cnt_q <= '0;
    end else if (ref_rise_i) begin
      if (ref_cnt_q == '0 || ref_cnt_q == RefLast) begin
        // first edge primes a full window; last edge closes one and opens the next
        ref_cnt_q  <= RW'(1);
        edge_cnt_q <= '0;
      end else begin
        ref_cnt_q  <= ref_cnt_q + 1'b1;
        edge_cnt_q <= edge_inc;
      end
    end else if (ref_cnt_q != '0) begin
      edge_cnt_q <= edge_inc;
    end
  end
endmodule

// File: rtl/xfd_ctrl.sv
module xfd_ctrl
  import xfd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xosc_en_i,
  input  logic       xosc_sel_i,
  input  logic       prot_open_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  input  logic       nmi_ack_i,
  input  logic       fail_evt_i,
  output logic       arm_o,
  output logic       det_en_o,
  output logic       fail_flag_o,
  output logic       nmi_req_o,
  output xfd_resp_t  resp_o
);
  logic tripped_q;

  assign arm_o = det_en_o & xosc_en_i & ~tripped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_en_o    <= 1'b0;
      tripped_q   <= 1'b0;
      fail_flag_o <= 1'b0;
      nmi_req_o   <= 1'b0;
      resp_o      <= '0;
    end else begin
      if (wr_en_i && prot_open_i && wr_data_i[WrEnBit]) det_en_o <= 1'b1;

      if (fail_evt_i)      tripped_q <= 1'b1;
      else if (!xosc_en_i) tripped_q <= 1'b0;

      if (fail_evt_i)                          fail_flag_o <= 1'b1;
      else if (wr_en_i && wr_data_i[WrClrBit]) fail_flag_o <= 1'b0;

      if (fail_evt_i)     nmi_req_o <= 1'b1;
      else if (nmi_ack_i) nmi_req_o <= 1'b0;

      resp_o.sw_int   <= fail_evt_i & xosc_sel_i;
      resp_o.xosc_off <= fail_evt_i;
      resp_o.lock_clr <= fail_evt_i;
    end
  end
endmodule

// File: rtl/xosc_fail_monitor.sv
module xosc_fail_monitor
  import xfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIN_REFS    = 3,
  parameter int unsigned MIN_EDGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       xosc_clk_i,
  input  logic       xosc_en_i,
  input  logic       xosc_sel_i,
  input  logic       prot_open_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  input  logic       nmi_ack_i,
  output logic       det_en_o,
  output logic       fail_flag_o,
  output logic       nmi_req_o,
  output logic       sw_int_o,
  output logic       xosc_off_o,
  output logic       lock_clr_o
);
  logic      ref_rise, xosc_rise, arm, fail_evt;
  xfd_resp_t resp;

  xfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i, .rst_ni, .async_i(ref_clk_i), .rise_o(ref_rise)
  );

  xfd_edge_sync #(.STAGES(SYNC_STAGES)) u_xosc_sync (
    .clk_i, .rst_ni, .async_i(xosc_clk_i), .rise_o(xosc_rise)
  );

  xfd_window #(.WIN_REFS(WIN_REFS), .MIN_EDGES(MIN_EDGES)) u_window (
    .clk_i, .rst_ni, .arm_i(arm), .ref_rise_i(ref_rise),
    .xosc_rise_i(xosc_rise), .fail_evt_o(fail_evt)
  );

  xfd_ctrl u_ctrl (
    .clk_i, .rst_ni, .xosc_en_i, .xosc_sel_i, .prot_open_i, .wr_en_i,
    .wr_data_i, .nmi_ack_i, .fail_evt_i(fail_evt), .arm_o(arm),
    .det_en_o, .fail_flag_o, .nmi_req_o, .resp_o(resp)
  );

  assign sw_int_o   = resp.sw_int;
  assign xosc_off_o = resp.xosc_off;
  assign lock_clr_o = resp.lock_clr;
endmodule

// File: rtl/xosc_fail_monitor_chk.sv
module xosc_fail_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_clk_i,
  input logic       xosc_clk_i,
  input logic       xosc_en_i,
  input logic       xosc_sel_i,
  input logic       prot_open_i,
  input logic       wr_en_i,
  input logic [1:0] wr_data_i,
  input logic       nmi_ack_i,
  input logic       det_en_o,
  input logic       fail_flag_o,
  input logic       nmi_req_o,
  input logic       sw_int_o,
  input logic       xosc_off_o,
  input logic       lock_clr_o
);
  p_en_needs_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_en_o) |-> $past(prot_open_i && wr_en_i && wr_data_i[0]));

  p_en_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_en_o |=> det_en_o);

  p_flag_with_response_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_flag_o) |-> xosc_off_o);

  p_switch_only_selected_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_int_o |-> $past(xosc_sel_i) && xosc_off_o);

  p_lock_clr_with_nmi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_clr_o |-> nmi_req_o && xosc_off_o);

  p_nmi_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o && !nmi_ack_i |=> nmi_req_o);

  p_no_trip_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xosc_off_o |-> det_en_o && $past(xosc_en_i));

  p_single_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xosc_off_o |=> !xosc_off_o);
endmodule

bind xosc_fail_monitor xosc_fail_monitor_chk u_chk (.*);

// File: tb/xosc_fail_monitor_bench.sv
`timescale 1ns/1ps
module xosc_fail_monitor_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ref_clk = 1'b0, xosc_clk = 1'b0;
  logic       xosc_en = 1'b0, xosc_sel = 1'b0, prot_open = 1'b0;
  logic       wr_en = 1'b0, nmi_ack = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic       det_en, fail_flag, nmi_req, sw_int, xosc_off, lock_clr;

  real ref_half  = 200.0;
  real xosc_half = 200.0;
  bit  xosc_run  = 1'b0;

  int total = 0, bad = 0;
  int n_sw = 0, n_off = 0, n_lock = 0;

  always #5 clk = ~clk;
  always begin #(ref_half); ref_clk = ~ref_clk; end
  always begin #(xosc_half); if (xosc_run) xosc_clk = ~xosc_clk; end

  always @(negedge clk) begin
    if (sw_int)   n_sw++;
    if (xosc_off) n_off++;
    if (lock_clr) n_lock++;
  end

  xosc_fail_monitor u_xosc_fail_monitor (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .xosc_clk_i(xosc_clk),
    .xosc_en_i(xosc_en), .xosc_sel_i(xosc_sel), .prot_open_i(prot_open),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .nmi_ack_i(nmi_ack),
    .det_en_o(det_en), .fail_flag_o(fail_flag), .nmi_req_o(nmi_req),
    .sw_int_o(sw_int), .xosc_off_o(xosc_off), .lock_clr_o(lock_clr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input bit prot, input logic [1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d; prot_open = prot;
    @(negedge clk); wr_en = 1'b0; wr_data = 2'b00; prot_open = 1'b0;
  endtask

  task automatic ack_nmi();
    @(negedge clk); nmi_ack = 1'b1;
    @(negedge clk); nmi_ack = 1'b0;
  endtask

  task automatic wait_refs(input int n);
    #(2.0 * 200.0 * n);
    @(negedge clk);
  endtask

  task automatic clr_counts();
    @(negedge clk); n_sw = 0; n_off = 0; n_lock = 0;
  endtask

  // bring oscillator back healthy and re-arm via xosc_en low
  task automatic rearm(input bit sel);
    xosc_en = 1'b0; xosc_half = 200.0; xosc_run = 1'b1;
    wait_refs(2);
    xosc_sel = sel; xosc_en = 1'b1;
    wait_refs(6);
    clr_counts();
  endtask

  task automatic t_reset();
    check("R1 det_en", det_en, 0);
    check("R1 fail_flag", fail_flag, 0);
    check("R1 nmi_req", nmi_req, 0);
    check("R1 pulses", n_sw + n_off + n_lock, 0);
  endtask

  task automatic t_unprotected_enable();
    write_reg(1'b0, 2'b01);
    check("R2 enable without window ignored", det_en, 0);
    xosc_en = 1'b1; xosc_run = 1'b0;
    wait_refs(8);
    check("R10 no trip while disabled nmi", nmi_req, 0);
    check("R10 no trip while disabled off", n_off, 0);
  endtask

  task automatic t_protected_enable();
    xosc_en = 1'b0;
    write_reg(1'b1, 2'b01);
    check("R2 enable in window", det_en, 1);
    write_reg(1'b1, 2'b00);
    write_reg(1'b0, 2'b00);
    check("R3 enable sticky", det_en, 1);
  endtask

  task automatic t_not_enabled_osc();
    xosc_en = 1'b0; xosc_run = 1'b0;
    wait_refs(8);
    check("R10 no trip with xosc_en low", n_off + nmi_req, 0);
  endtask

  task automatic t_healthy();
    rearm(1'b1);
    wait_refs(8);
    check("R4 nominal ref no trip", n_off + nmi_req, 0);
    ref_half = 140.0;
    wait_refs(10);
    check("R4 fast ref no trip", n_off + nmi_req, 0);
    ref_half = 260.0;
    wait_refs(8);
    check("R4 slow ref no trip", n_off + nmi_req, 0);
    ref_half = 200.0;
    wait_refs(4);
  endtask

  task automatic t_fail_selected();
    rearm(1'b1);
    xosc_run = 1'b0;
    wait_refs(12);
    check("R5 flag set", fail_flag, 1);
    check("R5 nmi set", nmi_req, 1);
    check("R5 off pulse", n_off, 1);
    check("R6 switch pulse selected", n_sw, 1);
    check("R7 lock clear pulse", n_lock, 1);
    check("R11 single response", n_off + n_sw + n_lock, 3);
    wait_refs(2);
    check("R8 nmi held without ack", nmi_req, 1);
    ack_nmi();
    check("R8 nmi cleared by ack", nmi_req, 0);
    check("R9 flag survives ack", fail_flag, 1);
    write_reg(1'b0, 2'b00);
    check("R9 flag survives write zero", fail_flag, 1);
    write_reg(1'b0, 2'b10);
    check("R9 flag cleared by write one", fail_flag, 0);
  endtask

  task automatic t_fail_unselected();
    rearm(1'b0);
    xosc_run = 1'b0;
    wait_refs(12);
    check("R6 off pulse unselected", n_off, 1);
    check("R6 no switch unselected", n_sw, 0);
    check("R6 nmi unselected", nmi_req, 1);
    check("R7 lock clear unselected", n_lock, 1);
    ack_nmi();
    write_reg(1'b0, 2'b10);
  endtask

  task automatic t_slow_osc();
    rearm(1'b1);
    xosc_half = 800.0;
    wait_refs(14);
    check("R4 quarter-rate oscillator trips", n_off, 1);
    check("R4 quarter-rate nmi", nmi_req, 1);
    ack_nmi();
  endtask

  initial begin
    fork
      begin
        #23 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unprotected_enable();
        t_protected_enable();
        t_not_enabled_osc();
        t_healthy();
        t_fail_selected();
        t_fail_unselected();
        t_slow_osc();
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule